// File: doc/BRIEF.md
# Complementing Adder with Shift Path

This block is the arithmetic core of a small two-address processor. It builds every data operation from one shared adder. A conditional inverter sits in front of operand A. A pass-or-zero gate sits in front of operand B. A selector supplies the carry-in as a constant 0, a constant 1, or the current carry flag.

Two mode controls reuse the same inputs:
- The right-shift mode moves the adjusted A down one place. The selected carry-in fills the top bit.
- The AND mode combines the two adjusted operands bit by bit.

With these paths, settings of the control inputs give the following operations:
- add and add-with-carry
- negate, complement and decrement
- bit-clear
- left shift, by adding a value to itself
- right shift and rotate
- no-op, and set-carry

The result and the next carry are combinational. The carry flag is the only register, and it loads only on cycles that the sequencer marks as execute. Memory access and instruction sequencing belong to the surrounding design.

Top module: `cmp_alu`

## Requirements
- R1: While `rst_n` is low, `carry_q` is 0.
- R2: In normal mode (`shr_sel`=0, `and_sel`=0), `result` is the low 8 bits of A'+B'+cin and `carry_next` is bit 8 of that sum. Here A' is `opnd_a`, inverted when `a_inv`=1. B' is `opnd_b` when `b_pass`=1 and 0 otherwise.
- R3: `a_inv`=1 presents the bitwise complement of `opnd_a` to every path. With B masked and cin=1, this gives the two's complement negation.
- R4: `b_pass`=0 forces B' to zero whatever the value of `opnd_b`.
- R5: cin is 1 when `cin_one`=1, whatever the value of `cin_flag`. Otherwise cin is `carry_q` when `cin_flag`=1, and 0 when neither is set.
- R6: When `shr_sel`=1, `result` = {cin, A'[7:1]} and `carry_next` = A'[0]. The shift takes precedence over `and_sel`.
- R7: When `and_sel`=1 and `shr_sel`=0, `result` = A' & B' and `carry_next` = 0. With `a_inv`=1 this clears the bits of B that are set in A.
- R8: `carry_q` loads `carry_next` on a rising clock edge only when `exec_en`=1. Otherwise it holds its value.
- R9: The no-op setting leaves the carry as it was. This setting is A=0xFF, `a_inv`=0, `b_pass`=0, `cin_flag`=1 in normal mode. The same setting with `cin_one`=1 gives `carry_next`=1 and `result`=0x00.
- R10: The left-shift setting gives `result` = {x[6:0], cin} and `carry_next` = x[7]. This setting has A=B=x, `b_pass`=1, `a_inv`=0, in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Execute cycle; enables the carry register load |
| opnd_a | input | 8 | Operand A |
| opnd_b | input | 8 | Operand B |
| b_pass | input | 1 | 1 passes B, 0 forces B to zero |
| a_inv | input | 1 | 1 complements A |
| cin_one | input | 1 | Forces carry-in to 1 |
| cin_flag | input | 1 | Takes carry-in from the carry flag |
| shr_sel | input | 1 | Right-shift mode |
| and_sel | input | 1 | Bitwise AND mode |
| result | output | 8 | Operation result |
| carry_next | output | 1 | Carry produced by the operation |
| carry_q | output | 1 | Registered carry flag |

## Verification
The assertions check the following on every cycle:
- the carry register's load-or-hold rule;
- the carry being cleared in AND mode;
- the carry taken from bit 0 of the adjusted A in shift mode, and the fill bit that shift mode places at bit 7;
- the set-carry setting.

The arithmetic values need the bench's directed scenarios. These include:
- sums that overflow;
- negation of 0 and of a nonzero value;
- the carry-in priority when both carry controls are set;
- the left-shift use of the adder;
- a carry that must survive a cycle with `exec_en` low.

// File: rtl/cmp_alu.sv
`timescale 1ns/1ps
module cmp_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_en,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         b_pass,
  input  logic         a_inv,
  input  logic         cin_one,
  input  logic         cin_flag,
  input  logic         shr_sel,
  input  logic         and_sel,
  output logic [W-1:0] result,
  output logic         carry_next,
  output logic         carry_q
);
  logic [W-1:0] a_adj, b_adj;
  logic         cin;
  logic [W:0]   sum;

  assign a_adj = a_inv ? ~opnd_a : opnd_a;
  assign b_adj = b_pass ? opnd_b : '0;
  assign cin   = cin_one | (cin_flag & carry_q);
  assign sum   = {1'b0, a_adj} + {1'b0, b_adj} + {{W{1'b0}}, cin};

  always_comb begin
    if (shr_sel) begin
      result     = {cin, a_adj[W-1:1]};
      carry_next = a_adj[0];
    end else if (and_sel) begin
      result     = a_adj & b_adj;
      carry_next = 1'b0;
    end else begin
      result     = sum[W-1:0];
      carry_next = sum[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       carry_q <= 1'b0;
    else if (exec_en) carry_q <= carry_next;
endmodule

module cmp_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         exec_en,
  input logic [W-1:0] opnd_a,
  input logic         b_pass,
  input logic         a_inv,
  input logic         cin_one,
  input logic         shr_sel,
  input logic         and_sel,
  input logic [W-1:0] result,
  input logic         carry_next,
  input logic         carry_q
);
  // R1
  always @(posedge clk) if (!rst_n) carry_reset_chk: assert (carry_q == 1'b0);

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable(carry_q));

  // R8
  carry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> carry_q == $past(carry_next));

  // R7
  and_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (and_sel && !shr_sel) |-> !carry_next);

  // R6
  shr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shr_sel |-> carry_next == (opnd_a[0] ^ a_inv));

  // R6
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shr_sel && cin_one) |-> result[W-1]);

  // R9
  set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cin_one && !b_pass && !a_inv && !shr_sel && !and_sel && (&opnd_a)) |-> (carry_next && result == '0));
endmodule

bind cmp_alu cmp_alu_chk #(.W(W)) u_chk (.*);

// File: tb/tb_cmp_alu.sv
`timescale 1ns/1ps
module tb_cmp_alu;
  logic clk = 0, rst_n = 0, exec_en = 0;
  logic [7:0] opnd_a = 0, opnd_b = 0;
  logic b_pass = 0, a_inv = 0, cin_one = 0, cin_flag = 0, shr_sel = 0, and_sel = 0;
  logic [7:0] result;
  logic carry_next, carry_q;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp_alu dut (.*);

  task automatic chk(string tag, logic [8:0] got, logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic drive(logic [7:0] a, logic [7:0] b, logic bp, logic inv,
                       logic c1, logic cf, logic shr, logic an);
    @(negedge clk);
    opnd_a = a; opnd_b = b; b_pass = bp; a_inv = inv;
    cin_one = c1; cin_flag = cf; shr_sel = shr; and_sel = an;
    #1;
  endtask

  task automatic op(string tag, logic [7:0] a, logic [7:0] b, logic bp, logic inv,
                    logic c1, logic cf, logic shr, logic an, logic [7:0] er, logic ec);
    drive(a, b, bp, inv, c1, cf, shr, an);
    chk(tag, {carry_next, result}, {ec, er});
  endtask

  task automatic load_carry(logic v);
    drive(v ? 8'hFF : 8'h00, 8'h00, 1'b0, 1'b0, v, 1'b0, 1'b0, 1'b0);
    exec_en = 1;
    @(negedge clk);
    exec_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset carry", {8'h00, carry_q}, 9'h000);
  endtask

  task automatic t_add;
    op("R2 add no carry", 8'h35, 8'h4A, 1, 0, 0, 0, 0, 0, 8'h7F, 0);
    op("R2 add overflow", 8'hC8, 8'h50, 1, 0, 0, 0, 0, 0, 8'h18, 1);
  endtask

  task automatic t_neg_mask;
    op("R3 negate 5", 8'h05, 8'h77, 0, 1, 1, 0, 0, 0, 8'hFB, 0);
    op("R3 negate 0", 8'h00, 8'h77, 0, 1, 1, 0, 0, 0, 8'h00, 1);
    op("R4 B masked", 8'h12, 8'hFF, 0, 0, 0, 0, 0, 0, 8'h12, 0);
  endtask

  task automatic t_cin;
    load_carry(1);
    op("R5 cin from flag", 8'h10, 8'h20, 1, 0, 0, 1, 0, 0, 8'h31, 0);
    load_carry(0);
    op("R5 cin flag clear", 8'h10, 8'h20, 1, 0, 0, 1, 0, 0, 8'h30, 0);
    op("R5 cin_one priority", 8'h10, 8'h20, 1, 0, 1, 1, 0, 0, 8'h31, 0);
  endtask

  task automatic t_shift;
    op("R6 shr fill one", 8'h81, 8'h00, 0, 0, 1, 0, 1, 0, 8'hC0, 1);
    op("R6 shr over and", 8'h02, 8'hFF, 1, 0, 0, 0, 1, 1, 8'h01, 0);
    op("R10 lsl", 8'h96, 8'h96, 1, 0, 0, 0, 0, 0, 8'h2C, 1);
    op("R10 lsl fill one", 8'h96, 8'h96, 1, 0, 1, 0, 0, 0, 8'h2D, 1);
  endtask

  task automatic t_and;
    load_carry(1);
    op("R7 and", 8'hF0, 8'h3C, 1, 0, 0, 0, 0, 1, 8'h30, 0);
    op("R7 bit clear", 8'h0C, 8'hFF, 1, 1, 0, 0, 0, 1, 8'hF3, 0);
    exec_en = 1;
    @(negedge clk);
    exec_en = 0;
    chk("R7 and clears flag", {8'h00, carry_q}, 9'h000);
  endtask

  task automatic t_hold;
    load_carry(1);
    op("R8 next zero", 8'h01, 8'h01, 1, 0, 0, 0, 0, 0, 8'h02, 0);
    @(negedge clk);
    chk("R8 hold without exec", {8'h00, carry_q}, 9'h001);
    exec_en = 1;
    @(negedge clk);
    exec_en = 0;
    chk("R8 load with exec", {8'h00, carry_q}, 9'h000);
  endtask

  task automatic t_nop;
    load_carry(1);
    op("R9 nop carry set", 8'hFF, 8'h55, 0, 0, 0, 1, 0, 0, 8'h00, 1);
    load_carry(0);
    op("R9 nop carry clear", 8'hFF, 8'h55, 0, 0, 0, 1, 0, 0, 8'hFF, 0);
    op("R9 set carry", 8'hFF, 8'h55, 0, 0, 1, 0, 0, 0, 8'h00, 1);
  endtask

  initial begin
    #1;
    t_reset();
    #22 rst_n = 1;
    t_add();
    t_neg_mask();
    t_cin();
    t_shift();
    t_and();
    t_hold();
    t_nop();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule